// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block forecasts whether a conditional branch will be taken by running two direction predictors side by side and letting a per-address arbiter pick between them. The first predictor is indexed only by the shift register of recent outcomes across all branches. The second works in two levels. It keeps a private outcome history for each branch slot, and that history selects a 3-bit confidence counter. A table of 2-bit arbiter counters, indexed by the branch address, learns which of the two is more reliable for each branch.

Lookup is purely combinational. The fetch stage presents an address and reads back the final direction together with both component directions. When a branch resolves, the core presents its address and real direction on the training port. On that clock edge both component counters train, the arbiter entry moves toward whichever predictor alone was right, and both histories shift in the outcome. Histories advance only on training, so prediction and training see the same non-speculative state.

Top module: `tournament_pred`

## Requirements
- R1: After reset every counter in both components reads weakly not taken, all histories are zero and every arbiter entry favours the global predictor, so all three prediction outputs are 0 for any address.
- R2: `pred_taken` equals `pred_local` when the arbiter entry's upper bit is 1 and `pred_global` when it is 0; when the two components agree, the final output equals them.
- R3: Each global counter is 2 bits, saturates at 0 and 3, steps up on a taken outcome and down on a not-taken one, and its upper bit is the global prediction; the counter read is the one addressed by the global history alone.
- R4: On each training event the global history (GH_W bits) shifts left and the outcome enters at bit 0 (1 = taken).
- R5: The per-branch history slot is selected by address bits [LHT_IDX_W+1:2]; on training it shifts left with the outcome at bit 0, and the slot's previous value addresses the local counter being trained.
- R6: Each local counter is 3 bits, reset to 3, saturates at 0 and 7, and its bit 2 is the local prediction.
- R7: The arbiter entry, selected by address bits [CH_IDX_W+1:2], increments (saturating at 3) when only the local component was right, and decrements (saturating at 0) when only the global component was right.
- R8: The arbiter entry is unchanged when both components were right or both were wrong.
- R9: With `upd_valid` low, no table or history changes, whatever `upd_pc` and `upd_taken` hold.
- R10: Address bits [1:0] have no effect on prediction or training.
- R11: Presenting addresses on the lookup port alone never changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Final direction (1 = taken) |
| pred_global | output | 1 | Direction from the global-history component |
| pred_local | output | 1 | Direction from the per-branch-history component |
| upd_valid | input | 1 | Training event this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction (1 = taken) |

## Verification
The bench targets the points where a near-miss design would still predict plausibly. Long runs of one outcome push counters against their rails, where a missing saturation wraps a strongly taken counter to not taken. Interleaved correlated branches make exactly one component right, exposing an arbiter that moves on agreement or moves the wrong way. A design that read the per-branch counter after the history shift, or that let idle cycles or the low address bits leak into the tables, would drift from the reference model within a few steps.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr2_t;
  typedef logic [2:0] ctr3_t;

  localparam ctr2_t CTR2_WEAK_NT   = 2'b01;
  localparam ctr3_t CTR3_WEAK_NT   = 3'b011;
  localparam ctr2_t ARB_WEAK_GLOB  = 2'b01;

  function automatic ctr2_t ctr2_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == 2'b11) ? c : c + 2'b01;
    else    r = (c == 2'b00) ? c : c - 2'b01;
    return r;
  endfunction

  function automatic ctr3_t ctr3_step(input ctr3_t c, input logic up);
    ctr3_t r;
    if (up) r = (c == 3'b111) ? c : c + 3'b001;
    else    r = (c == 3'b000) ? c : c - 3'b001;
    return r;
  endfunction

endpackage

// File: rtl/tp_global_pred.sv
module tp_global_pred
  import tp_pkg::*;
#(
  parameter int GH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic            upd_taken,
  output logic            dir_o,
  output logic [GH_W-1:0] ghist_o
);
  localparam int DEPTH = 1 << GH_W;

  ctr2_t           pht_q [DEPTH];
  logic [GH_W-1:0] ghist_q, ghist_d;
  ctr2_t           cnt_d;

  always_comb begin
    ghist_d = {ghist_q[GH_W-2:0], upd_taken};
    cnt_d   = ctr2_step(pht_q[ghist_q], upd_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghist_q <= '0;
      for (int i = 0; i < DEPTH; i++) pht_q[i] <= CTR2_WEAK_NT;
    end else if (upd_en) begin
      ghist_q          <= ghist_d;
      pht_q[ghist_q]   <= cnt_d;
    end
  end

  assign dir_o   = pht_q[ghist_q][1];
  assign ghist_o = ghist_q;

endmodule

// File: rtl/tp_local_pred.sv
module tp_local_pred
  import tp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int LH_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] pred_idx,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_en,
  input  logic             upd_taken,
  output logic             dir_o,
  output logic             upd_dir_o,
  output logic [LH_W-1:0]  upd_hist_o
);
  localparam int HT_DEPTH  = 1 << IDX_W;
  localparam int CT_DEPTH  = 1 << LH_W;

  logic [LH_W-1:0] hist_q [HT_DEPTH];
  ctr3_t           cnt_q  [CT_DEPTH];

  logic [LH_W-1:0] hist_rd_p, hist_rd_u, hist_d;
  ctr3_t           cnt_d;

  always_comb begin
    hist_rd_p = hist_q[pred_idx];
    hist_rd_u = hist_q[upd_idx];
    hist_d    = {hist_rd_u[LH_W-2:0], upd_taken};
    cnt_d     = ctr3_step(cnt_q[hist_rd_u], upd_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HT_DEPTH; i++) hist_q[i] <= '0;
      for (int j = 0; j < CT_DEPTH; j++) cnt_q[j]  <= CTR3_WEAK_NT;
    end else if (upd_en) begin
      hist_q[upd_idx]  <= hist_d;
      cnt_q[hist_rd_u] <= cnt_d;
    end
  end

  assign dir_o      = cnt_q[hist_rd_p][2];
  assign upd_dir_o  = cnt_q[hist_rd_u][2];
  assign upd_hist_o = hist_rd_u;

endmodule

// File: rtl/tp_chooser.sv
module tp_chooser
  import tp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] pred_idx,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_en,
  input  logic             glob_ok,
  input  logic             loc_ok,
  output logic             use_local_o,
  output ctr2_t            upd_cnt_o
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t arb_q [DEPTH];
  ctr2_t arb_d;
  logic  arb_we;

  always_comb begin
    arb_we = upd_en && (glob_ok != loc_ok);
    arb_d  = ctr2_step(arb_q[upd_idx], loc_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) arb_q[i] <= ARB_WEAK_GLOB;
    end else if (arb_we) begin
      arb_q[upd_idx] <= arb_d;
    end
  end

  assign use_local_o = arb_q[pred_idx][1];
  assign upd_cnt_o   = arb_q[upd_idx];

endmodule

// File: rtl/tournament_pred.sv
module tournament_pred
  import tp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int GH_W      = 8,
  parameter int LHT_IDX_W = 6,
  parameter int LH_W      = 6,
  parameter int CH_IDX_W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_global,
  output logic            pred_local,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int LHT_LSB = 2;
  localparam int LHT_MSB = LHT_IDX_W + 1;
  localparam int CH_MSB  = CH_IDX_W + 1;

  logic rst_s1_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_core_n <= rst_s1_q;
    end
  end

  logic            upd_glob_bit, upd_loc_bit, use_local;
  logic            glob_ok, loc_ok;
  logic [GH_W-1:0] ghist;
  logic [LH_W-1:0] lh_u;
  ctr2_t           ch_cnt_u;
  logic            unused_pc;

  assign unused_pc = ^{pred_pc, upd_pc};

  tp_global_pred #(.GH_W(GH_W)) u_glob (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .upd_en    (upd_valid),
    .upd_taken (upd_taken),
    .dir_o     (pred_global),
    .ghist_o   (ghist)
  );

  // Global index has no address term, so the lookup and training reads coincide.
  assign upd_glob_bit = pred_global;

  tp_local_pred #(.IDX_W(LHT_IDX_W), .LH_W(LH_W)) u_loc (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .pred_idx   (pred_pc[LHT_MSB:LHT_LSB]),
    .upd_idx    (upd_pc[LHT_MSB:LHT_LSB]),
    .upd_en     (upd_valid),
    .upd_taken  (upd_taken),
    .dir_o      (pred_local),
    .upd_dir_o  (upd_loc_bit),
    .upd_hist_o (lh_u)
  );

  always_comb begin
    glob_ok = (upd_glob_bit == upd_taken);
    loc_ok  = (upd_loc_bit  == upd_taken);
  end

  tp_chooser #(.IDX_W(CH_IDX_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .pred_idx    (pred_pc[CH_MSB:2]),
    .upd_idx     (upd_pc[CH_MSB:2]),
    .upd_en      (upd_valid),
    .glob_ok     (glob_ok),
    .loc_ok      (loc_ok),
    .use_local_o (use_local),
    .upd_cnt_o   (ch_cnt_u)
  );

  assign pred_taken = use_local ? pred_local : pred_global;

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int PC_W = 32,
  parameter int GH_W = 8,
  parameter int LH_W = 6
) (
  input logic            clk,
  input logic            rst_core_n,
  input logic            upd_valid,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_pc,
  input logic            pred_taken,
  input logic            pred_global,
  input logic            pred_local,
  input logic            upd_glob_bit,
  input logic            upd_loc_bit,
  input logic [GH_W-1:0] ghist,
  input logic [LH_W-1:0] lh_u,
  input logic [1:0]      ch_cnt_u
);

  p_agree_pick_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pred_global == pred_local) |-> (pred_taken == pred_global));

  p_ghist_shift_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    upd_valid |=> (ghist == {$past(ghist[GH_W-2:0]), $past(upd_taken)}));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !upd_valid |=> $stable(ghist));

  p_lhist_shift_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    upd_valid |=> ((upd_pc != $past(upd_pc)) ||
                   (lh_u == {$past(lh_u[LH_W-2:0]), $past(upd_taken)})));

  p_arb_up_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (upd_valid && (upd_loc_bit == upd_taken) && (upd_glob_bit != upd_taken)) |=>
      ((upd_pc != $past(upd_pc)) ||
       (ch_cnt_u == (($past(ch_cnt_u) == 2'd3) ? 2'd3 : $past(ch_cnt_u) + 2'd1))));

  p_arb_hold_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (upd_valid && ((upd_loc_bit == upd_taken) == (upd_glob_bit == upd_taken))) |=>
      ((upd_pc != $past(upd_pc)) || (ch_cnt_u == $past(ch_cnt_u))));

endmodule

bind tournament_pred tp_checker #(.PC_W(PC_W), .GH_W(GH_W), .LH_W(LH_W)) u_chk (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .upd_valid    (upd_valid),
  .upd_taken    (upd_taken),
  .upd_pc       (upd_pc),
  .pred_taken   (pred_taken),
  .pred_global  (pred_global),
  .pred_local   (pred_local),
  .upd_glob_bit (upd_glob_bit),
  .upd_loc_bit  (upd_loc_bit),
  .ghist        (ghist),
  .lh_u         (lh_u),
  .ch_cnt_u     (ch_cnt_u)
);

// File: tb/tournament_pred_tb.sv
module tournament_pred_tb;
  localparam int PC_W = 32;
  localparam int GH_W = 8;
  localparam int LI_W = 6;
  localparam int LH_W = 6;
  localparam int CI_W = 8;

  logic clk, rst_n;
  logic [PC_W-1:0] pred_pc, upd_pc;
  logic pred_taken, pred_global, pred_local, upd_valid, upd_taken;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  tournament_pred #(.PC_W(PC_W), .GH_W(GH_W), .LHT_IDX_W(LI_W), .LH_W(LH_W),
                    .CH_IDX_W(CI_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_global(pred_global), .pred_local(pred_local), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken));

  initial clk = 0;
  always #2.5 clk = ~clk;

  // Reference model built from the requirements
  logic [GH_W-1:0] m_gh;
  logic [1:0]      m_gp [1<<GH_W];
  logic [LH_W-1:0] m_lh [1<<LI_W];
  logic [2:0]      m_lp [1<<LH_W];
  logic [1:0]      m_ch [1<<CI_W];

  function automatic int li(input logic [PC_W-1:0] pc); return int'(pc[LI_W+1:2]); endfunction
  function automatic int ci(input logic [PC_W-1:0] pc); return int'(pc[CI_W+1:2]); endfunction

  task automatic m_reset();
    m_gh = '0;
    for (int i = 0; i < (1<<GH_W); i++) m_gp[i] = 2'b01;
    for (int i = 0; i < (1<<LI_W); i++) m_lh[i] = '0;
    for (int i = 0; i < (1<<LH_W); i++) m_lp[i] = 3'b011;
    for (int i = 0; i < (1<<CI_W); i++) m_ch[i] = 2'b01;
  endtask

  task automatic m_update(input logic [PC_W-1:0] pc, input logic t);
    logic g, l; logic [LH_W-1:0] h;
    h = m_lh[li(pc)];
    g = m_gp[m_gh][1];
    l = m_lp[h][2];
    if (t) begin
      if (m_gp[m_gh] != 2'd3) m_gp[m_gh] = m_gp[m_gh] + 2'd1;
      if (m_lp[h] != 3'd7) m_lp[h] = m_lp[h] + 3'd1;
    end else begin
      if (m_gp[m_gh] != 2'd0) m_gp[m_gh] = m_gp[m_gh] - 2'd1;
      if (m_lp[h] != 3'd0) m_lp[h] = m_lp[h] - 3'd1;
    end
    if ((l == t) && (g != t) && m_ch[ci(pc)] != 2'd3) m_ch[ci(pc)] = m_ch[ci(pc)] + 2'd1;
    if ((g == t) && (l != t) && m_ch[ci(pc)] != 2'd0) m_ch[ci(pc)] = m_ch[ci(pc)] - 2'd1;
    m_gh = {m_gh[GH_W-2:0], t};
    m_lh[li(pc)] = {h[LH_W-2:0], t};
  endtask

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: %s got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic [PC_W-1:0] ppc, input logic uv,
                      input logic [PC_W-1:0] upc, input logic ut);
    logic g, l, f;
    @(negedge clk);
    pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    #1;
    g = m_gp[m_gh][1];
    l = m_lp[m_lh[li(ppc)]][2];
    f = m_ch[ci(ppc)][1] ? l : g;
    check(tag, "pred_global", pred_global, g);
    check(tag, "pred_local",  pred_local,  l);
    check(tag, "pred_taken",  pred_taken,  f);
    @(posedge clk);
    if (uv) m_update(upc, ut);
  endtask

  task automatic t_reset();  // R1
    foreach (pred_pc[i]) ;
    step("R1", 32'h0, 0, 0, 0);
    step("R1", 32'h4, 0, 0, 0);
    step("R1", 32'h100, 0, 0, 0);
    step("R1", 32'hFFC, 0, 0, 0);
    check("R1", "pred_taken after reset", pred_taken, 1'b0);
  endtask

  task automatic t_global_sat();  // R3 R4: long taken run, then a single not-taken
    for (int i = 0; i < 14; i++) step("R3", 32'h40, 1, 32'h40, 1);
    step("R4", 32'h40, 1, 32'h40, 0);
    step("R3", 32'h40, 1, 32'h40, 1);
    for (int i = 0; i < 10; i++) step("R3", 32'h40, 1, 32'h40, 0);
  endtask

  task automatic t_local_loop();  // R5 R6: period-4 loop branch
    for (int k = 0; k < 10; k++)
      for (int j = 0; j < 4; j++) step("R6", 32'h80, 1, 32'h80, (j != 3));
    for (int j = 0; j < 4; j++) step("R5", 32'h84, 1, 32'h84, 1);
  endtask

  task automatic t_chooser();  // R7 R8: correlated pair of branches
    logic a;
    a = 0;
    for (int k = 0; k < 24; k++) begin
      a = ~a;
      step("R7", 32'h200, 1, 32'h200, a);
      step("R8", 32'h204, 1, 32'h204, a);
    end
    for (int k = 0; k < 6; k++) step("R2", 32'h200, 0, 0, 0);
  endtask

  task automatic t_idle();  // R9
    for (int k = 0; k < 8; k++)
      step("R9", 32'h80 + 4*k, 0, 32'h40 + 4*k, k[0]);
    step("R9", 32'h40, 0, 32'h40, 1);
  endtask

  task automatic t_offset();  // R10
    step("R10", 32'h81, 0, 0, 0);
    step("R10", 32'h82, 0, 0, 0);
    step("R10", 32'h83, 1, 32'h83, 1);
    step("R10", 32'h80, 1, 32'h82, 0);
    step("R10", 32'h201, 0, 0, 0);
  endtask

  task automatic t_mixed();  // R2 R11
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R2", {24'h0, lf[7:2], 2'b00}, 1, {26'h0, lf[5:3], 3'b000}, lf[8] ^ lf[3]);
    end
    for (int k = 0; k < 40; k++) step("R11", 32'h4 * k, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0; upd_valid = 0; upd_taken = 0; pred_pc = 0; upd_pc = 0;
    m_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    t_reset();
    t_global_sat();
    t_local_loop();
    t_chooser();
    t_idle();
    t_offset();
    t_mixed();
    @(negedge clk); upd_valid = 0;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule